// File: doc/BRIEF.md
# Indexed Edge Detection Bank

This block watches a wide input vector, one single-bit detector per lane, and reports edges on it. Each detector holds a two-bit code that sets which transitions count: low-to-high, high-to-low, or any change. A one-bit mask per detector silences it. The result is a per-cycle event vector and a single flag that is set when any event bit is set.

Software programs the detectors one at a time. It first writes a selector register that names a detector, then writes either a code or a mask value. That write changes only the detector the selector currently names. Read-back views present every code packed sixteen to a word and every mask packed thirty-two to a word. Reads are combinational from a read address, and writes take effect at the clock edge where `wr_en` is high.

Address map (6-bit): 0 selector, 1 code write, 2 mask write, 16 to 31 code words, 32 to 39 mask words. Every other read address returns zero.

Top module: `edb_bank`

## Requirements
- R1: After reset, the selector reads 0, every code word and mask word reads 0, `ev` is all zero and `any_ev` is 0.
- R2: A write to address 0 with a value below NUM_CH loads the selector, and address 0 reads it back. The selector changes only on such a write.
- R3: A write to address 1 stores wr_data[1:0] as the code of the selected detector only. Detector i reads back at address 16 + i/16, bits [2*(i%16)+1 : 2*(i%16)].
- R4: A code write is ignored if its value is 3 or if any of wr_data[31:2] is set. The stored code then stays as it was.
- R5: A write to address 2 with value 0 or 1 stores the mask of the selected detector. Other values are ignored. Detector i reads back at address 32 + i/32, bit i%32.
- R6: Code 0 gives an event on a 0-to-1 change of the lane.
- R7: Code 1 gives an event on a 1-to-0 change of the lane.
- R8: Code 2 gives an event on any change of the lane.
- R9: A masked detector never sets its event bit and never contributes to `any_ev`.
- R10: Events are registered. Edge k compares the input with the sample taken at edge k-1, and `ev` and `any_ev` show the result after edge k. `any_ev` equals the OR of `ev`.
- R11: The first clock edge after reset produces no events, whatever the input holds.
- R12: A code or mask write at the same edge as an input change is judged with the setting from before that write.
- R13: Reads of addresses outside the map return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 32 | Read data, combinational |
| din | input | NUM_CH | Watched input lanes |
| ev | output | NUM_CH | Registered per-lane events |
| any_ev | output | 1 | Registered OR of the events |

## Verification
Configuration writes and edge detection can both fall on the same clock edge. The bench raises a lane in the same cycle that it writes a mask for that lane. It expects the event to appear, because the old mask applies. On the next rising edge of that lane, with the mask now in force, it expects no event and `any_ev` low.

// File: rtl/edb_pkg.sv
package edb_pkg;
    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_RSVD = 2'd3
    } edge_code_e;

    localparam logic [5:0] A_SEL       = 6'd0;
    localparam logic [5:0] A_CODE      = 6'd1;
    localparam logic [5:0] A_MASK      = 6'd2;
    localparam int         CODE_BASE   = 16;
    localparam int         MASK_BASE   = 32;
endpackage

// File: rtl/edb_cfg.sv
module edb_cfg
    import edb_pkg::*;
#(
    parameter int NUM_CH = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [5:0]             wr_addr,
    input  logic [31:0]            wr_data,
    output logic [$clog2(NUM_CH)-1:0] sel,
    output logic [2*NUM_CH-1:0]    code_flat,
    output logic [NUM_CH-1:0]      mask_flat
);
    localparam int SEL_W = $clog2(NUM_CH);

    typedef struct packed {
        logic [SEL_W-1:0]    sel;
        logic [2*NUM_CH-1:0] code;
        logic [NUM_CH-1:0]   mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (wr_addr)
                A_SEL: begin
                    if (wr_data < 32'(NUM_CH))
                        cfg_d.sel = wr_data[SEL_W-1:0];
                end
                A_CODE: begin
                    if (wr_data[31:2] == '0 && edge_code_e'(wr_data[1:0]) != EDGE_RSVD)
                        cfg_d.code[2*cfg_q.sel +: 2] = wr_data[1:0];
                end
                A_MASK: begin
                    if (wr_data[31:1] == '0)
                        cfg_d.mask[cfg_q.sel] = wr_data[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign sel       = cfg_q.sel;
    assign code_flat = cfg_q.code;
    assign mask_flat = cfg_q.mask;
endmodule

// File: rtl/edb_readback.sv
module edb_readback
    import edb_pkg::*;
#(
    parameter int NUM_CH = 256
) (
    input  logic [5:0]                rd_addr,
    input  logic [$clog2(NUM_CH)-1:0] sel,
    input  logic [2*NUM_CH-1:0]       code_flat,
    input  logic [NUM_CH-1:0]         mask_flat,
    output logic [31:0]               rd_data
);
    localparam int CODE_WORDS = (2*NUM_CH + 31) / 32;
    localparam int MASK_WORDS = (NUM_CH + 31) / 32;

    logic [32*CODE_WORDS-1:0] code_pad;
    logic [32*MASK_WORDS-1:0] mask_pad;

    assign code_pad = (32*CODE_WORDS)'(code_flat);
    assign mask_pad = (32*MASK_WORDS)'(mask_flat);

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_SEL)
            rd_data = 32'(sel);
        for (int k = 0; k < CODE_WORDS; k++)
            if (rd_addr == 6'(CODE_BASE + k))
                rd_data = code_pad[32*k +: 32];
        for (int k = 0; k < MASK_WORDS; k++)
            if (rd_addr == 6'(MASK_BASE + k))
                rd_data = mask_pad[32*k +: 32];
    end
endmodule

// File: rtl/edb_detect.sv
module edb_detect
    import edb_pkg::*;
#(
    parameter int NUM_CH = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   din,
    input  logic [2*NUM_CH-1:0] code_flat,
    input  logic [NUM_CH-1:0]   mask_flat,
    output logic [NUM_CH-1:0]   ev,
    output logic                any_ev
);
    typedef struct packed {
        logic [NUM_CH-1:0] prev;
        logic              armed;
        logic [NUM_CH-1:0] ev;
        logic              any;
    } det_t;

    det_t det_d, det_q;
    logic [NUM_CH-1:0] hit;

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
            logic up, down;
            assign up   =  din[i] & ~det_q.prev[i];
            assign down = ~din[i] &  det_q.prev[i];
            always_comb begin
                unique case (edge_code_e'(code_flat[2*i +: 2]))
                    EDGE_RISE: hit[i] = up;
                    EDGE_FALL: hit[i] = down;
                    EDGE_BOTH: hit[i] = up | down;
                    default:   hit[i] = 1'b0;
                endcase
            end
        end
    endgenerate

    always_comb begin
        det_d       = det_q;
        det_d.prev  = din;
        det_d.armed = 1'b1;
        det_d.ev    = det_q.armed ? (hit & ~mask_flat) : '0;
        det_d.any   = |det_d.ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign ev     = det_q.ev;
    assign any_ev = det_q.any;
endmodule

// File: rtl/edb_bank.sv
module edb_bank
    import edb_pkg::*;
#(
    parameter int NUM_CH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [5:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [5:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic [NUM_CH-1:0] din,
    output logic [NUM_CH-1:0] ev,
    output logic              any_ev
);
    localparam int SEL_W = $clog2(NUM_CH);

    logic [SEL_W-1:0]    sel;
    logic [2*NUM_CH-1:0] code_flat;
    logic [NUM_CH-1:0]   mask_flat;

    edb_cfg #(.NUM_CH(NUM_CH)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sel(sel), .code_flat(code_flat), .mask_flat(mask_flat)
    );

    edb_readback #(.NUM_CH(NUM_CH)) u_rb (
        .rd_addr(rd_addr), .sel(sel), .code_flat(code_flat),
        .mask_flat(mask_flat), .rd_data(rd_data)
    );

    edb_detect #(.NUM_CH(NUM_CH)) u_det (
        .clk(clk), .rst_n(rst_n), .din(din), .code_flat(code_flat),
        .mask_flat(mask_flat), .ev(ev), .any_ev(any_ev)
    );
endmodule

// File: rtl/edb_bank_chk.sv
module edb_bank_chk #(
    parameter int NUM_CH = 256
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [$clog2(NUM_CH)-1:0] sel,
    input logic [2*NUM_CH-1:0]       code_flat,
    input logic [NUM_CH-1:0]         mask_flat,
    input logic [NUM_CH-1:0]         ev,
    input logic                      any_ev
);
    logic has_rsvd;
    always_comb begin
        has_rsvd = 1'b0;
        for (int i = 0; i < NUM_CH; i++)
            if (code_flat[2*i +: 2] == 2'd3) has_rsvd = 1'b1;
    end

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sel)); // R2
    AST_NO_RSVD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !has_rsvd); // R4
    AST_MASK_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ev & $past(mask_flat)) == '0); // R9
    AST_ANY_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
        any_ev == (|ev)); // R10
    AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rst_n, 2)) |-> (ev == '0 && !any_ev)); // R11
endmodule

bind edb_bank edb_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel),
    .code_flat(code_flat), .mask_flat(mask_flat), .ev(ev), .any_ev(any_ev)
);

// File: tb/edb_bank_test.sv
module edb_bank_test;
    localparam int N = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [5:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [5:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic [N-1:0]  din = '0;
    logic [N-1:0]  ev;
    logic          any_ev;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    edb_bank #(.NUM_CH(N)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .din(din), .ev(ev), .any_ev(any_ev)
    );

    // lanes used by the vector table: ch0 rise, ch5 fall, ch17 both, ch200 rise+masked, ch255 both
    localparam int LANE [5] = '{0, 5, 17, 200, 255};
    typedef struct packed { logic [4:0] din; logic [4:0] exp; } row_t;
    localparam int NROW = 7;
    localparam row_t TABLE [NROW] = '{
        '{5'b01111, 5'b00101},
        '{5'b01111, 5'b00000},
        '{5'b10000, 5'b10110},
        '{5'b00000, 5'b10000},
        '{5'b01000, 5'b00000},
        '{5'b01001, 5'b00001},
        '{5'b00000, 5'b00000}
    };

    function automatic logic [N-1:0] spread(input logic [4:0] b);
        logic [N-1:0] v = '0;
        for (int k = 0; k < 5; k++) v[LANE[k]] = b[k];
        return v;
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_ev(input string req, input logic [N-1:0] exp_v, input logic exp_a);
        checks++;
        if (ev !== exp_v || any_ev !== exp_a) begin
            fails++;
            $display("FAIL %s actual=%h/%b expected=%h/%b", req, ev, any_ev, exp_v, exp_a);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        check32(req, rd_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        din = '1;                                   // R11: ones held through reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check_ev("R11", '0, 1'b0);
        din = '0;                                   // falls under rising codes: no events
        @(posedge clk); @(negedge clk);
        check_ev("R11", '0, 1'b0);

        // R1: reset state through read-back
        rd_check("R1", 6'd0, 32'd0);
        rd_check("R1", 6'd16, 32'd0);
        rd_check("R1", 6'd32, 32'd0);

        // configure lanes
        wr(6'd0, 32'd5);   wr(6'd1, 32'd1);
        wr(6'd0, 32'd17);  wr(6'd1, 32'd2);
        rd_check("R2", 6'd0, 32'd17);
        wr(6'd0, 32'd255); wr(6'd1, 32'd2);
        wr(6'd0, 32'd200); wr(6'd2, 32'd1);
        wr(6'd0, 32'd300);                          // out of range: ignored
        rd_check("R2", 6'd0, 32'd200);
        rd_check("R3", 6'd16, 32'h0000_0400);
        rd_check("R3", 6'd17, 32'h0000_0008);
        rd_check("R3", 6'd31, 32'h8000_0000);
        rd_check("R5", 6'd38, 32'h0000_0100);
        wr(6'd2, 32'd2);                            // R5: illegal mask value ignored
        rd_check("R5", 6'd38, 32'h0000_0100);
        wr(6'd0, 32'd5);
        wr(6'd1, 32'd3);                            // R4: reserved code
        rd_check("R4", 6'd16, 32'h0000_0400);
        wr(6'd1, 32'h0000_0100);                    // R4: high bits set
        rd_check("R4", 6'd16, 32'h0000_0400);
        rd_check("R13", 6'd3, 32'd0);
        rd_check("R13", 6'd63, 32'd0);

        // R6 R7 R8 R9 R10: vector table
        for (int r = 0; r < NROW; r++) begin
            @(negedge clk);
            din = spread(TABLE[r].din);
            @(posedge clk); @(negedge clk);
            check_ev($sformatf("R6/R7/R8/R9/R10 row%0d", r), spread(TABLE[r].exp), |TABLE[r].exp);
        end

        // R12: mask ch0 at the same edge as its rise
        wr(6'd0, 32'd0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'd2; wr_data = 32'd1; din[0] = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        check_ev("R12", spread(5'b00001), 1'b1);
        din[0] = 1'b0;
        @(posedge clk); @(negedge clk);
        din[0] = 1'b1;
        @(posedge clk); @(negedge clk);
        check_ev("R12", '0, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule